// File: doc/BRIEF.md
# Serial Configuration Packet Receiver

This block accepts a one-bit configuration stream together with its programming clock and sets the per-channel settings of a four-channel recording module. Every rising clock edge moves one new bit into a 56-bit window. The bit that arrives first is the most significant bit of the window. No chip select and no framing strobe exist. A packet is recognised when two conditions hold together: the top 13 bits of the window equal a fixed sync word, and the next 8 bits equal the module's strapped address. When both hold, the remaining 35 bits are copied into holding registers.

The holding registers drive four channel settings and one comparator bias code. Each channel setting is a front-end bias code, a gain code and a mode bit. A packet that carries another module's address or a damaged sync word is ignored. This lets many modules share one data line and one clock, with each module picking out only its own packets.

Top module: `cfgrx_top`

## Requirements
- R1: Bits shift in on the rising edge of `clk`, and the first bit received becomes the window MSB. The settings reflect a packet on the same rising edge that shifts in its 56th bit. One edge earlier they still show the previous settings.
- R2: A packet is accepted only if its first 13 bits are 1111100110101, in arrival order.
- R3: A packet is accepted only if its next 8 bits, sent MSB first, equal `node_addr`.
- R4: The 35 payload bits are applied in arrival order, with channel 0 first and channel 3 last. Each channel takes 8 bits in this order: a 4-bit bias code, a 3-bit gain code, then a mode bit. On the output ports, channel c appears at `bias_code[4c+3:4c]`, `gain_code[3c+2:3c]` and `mode_bits[c]`.
- R5: The last 3 payload bits drive `cmp_bias`.
- R6: A packet can begin at any bit position. Any number of earlier bits does not prevent its recognition.
- R7: A packet with a wrong address or a wrong sync word leaves every output unchanged.
- R8: A synchronous active-high `rst` clears the window and all settings to zero on the next rising edge.
- R9: The window is not cleared after a match. The tail of an accepted packet can form the sync word and address of a following packet, and that packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Programming clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial configuration bit |
| node_addr | input | 8 | Strapped module address |
| bias_code | output | 16 | Front-end bias codes, 4 bits per channel |
| gain_code | output | 12 | Gain codes, 3 bits per channel |
| mode_bits | output | 4 | Mode bit per channel |
| cmp_bias | output | 3 | Comparator preamplifier bias code |

## Verification
Some rules are checked by assertions on every cycle. These are: the window shifts by exactly one bit per edge, a load never happens when the sync or address field disagrees, the settings stay unchanged on every non-loading edge, a load copies the window payload, and reset clears the settings. Other behaviour can only be shown by the bench scenarios. These are: the exact field placement on the output ports, the cycle on which new settings appear, recognition after leading stray bits, and a second packet formed out of the tail of an accepted one.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    localparam int SYNC_W = 13;
    localparam int ADDR_W = 8;
    localparam int NCH    = 4;
    localparam int BIAS_W = 4;
    localparam int GAIN_W = 3;
    localparam int CMP_W  = 3;
    localparam int CH_W   = BIAS_W + GAIN_W + 1;
    localparam int PAY_W  = NCH * CH_W + CMP_W;
    localparam int PKT_W  = SYNC_W + ADDR_W + PAY_W;

    localparam logic [SYNC_W-1:0] SYNC_WORD = 13'b1111100110101;

    typedef struct packed {
        logic [BIAS_W-1:0] bias;
        logic [GAIN_W-1:0] gain;
        logic              mode;
    } chan_cfg_t;

    // channel 0 occupies the most significant slot (ascending packed range)
    typedef struct packed {
        chan_cfg_t [0:NCH-1] ch;
        logic [CMP_W-1:0]    cmp;
    } mod_cfg_t;

    typedef struct packed {
        logic [SYNC_W-1:0] sync;
        logic [ADDR_W-1:0] addr;
        mod_cfg_t          pay;
    } pkt_t;

    function automatic logic sync_matches(logic [SYNC_W-1:0] s);
        return s == SYNC_WORD;
    endfunction

endpackage

// File: rtl/cfgrx_shift.sv
module cfgrx_shift #(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         din,
    output logic [W-1:0] win_next
);
    logic [W-1:0] win_q;

    assign win_next = {win_q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_next;
    end

    // R1: one-bit shift per edge, newest bit at the LSB
    p_shift_one_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (win_q[W-1:1] == $past(win_q[W-2:0])) && (win_q[0] == $past(din)));

endmodule

// File: rtl/cfgrx_match.sv
module cfgrx_match
    import cfgrx_pkg::*;
(
    input  logic [SYNC_W-1:0] sync_f,
    input  logic [ADDR_W-1:0] addr_f,
    input  logic [ADDR_W-1:0] node_addr,
    output logic              hit
);
    logic sync_hit;
    logic addr_hit;

    always_comb begin
        sync_hit = sync_matches(sync_f);
        addr_hit = (addr_f == node_addr);
        hit      = sync_hit && addr_hit;
    end

endmodule

// File: rtl/cfgrx_store.sv
module cfgrx_store
    import cfgrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  mod_cfg_t nxt,
    output mod_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst)       cfg <= '0;
        else if (load) cfg <= nxt;
    end

    // R7: settings only move on a load
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg));

    // R4: a load copies the payload of the window
    p_copy_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> cfg == $past(nxt));

    // R8: reset clears the settings
    p_clear_r8: assert property (@(posedge clk)
        rst |=> cfg == '0);

endmodule

// File: rtl/cfgrx_top.sv
module cfgrx_top
    import cfgrx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ser_data,
    input  logic [ADDR_W-1:0]       node_addr,
    output logic [NCH*BIAS_W-1:0]   bias_code,
    output logic [NCH*GAIN_W-1:0]   gain_code,
    output logic [NCH-1:0]          mode_bits,
    output logic [CMP_W-1:0]        cmp_bias
);
    logic [PKT_W-1:0] win_next;
    pkt_t             cand;
    logic             hit;
    mod_cfg_t         cfg;

    cfgrx_shift #(.W(PKT_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .din      (ser_data),
        .win_next (win_next)
    );

    assign cand = pkt_t'(win_next);

    cfgrx_match u_match (
        .sync_f    (cand.sync),
        .addr_f    (cand.addr),
        .node_addr (node_addr),
        .hit       (hit)
    );

    cfgrx_store u_store (
        .clk  (clk),
        .rst  (rst),
        .load (hit),
        .nxt  (cand.pay),
        .cfg  (cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign bias_code[c*BIAS_W +: BIAS_W] = cfg.ch[c].bias;
        assign gain_code[c*GAIN_W +: GAIN_W] = cfg.ch[c].gain;
        assign mode_bits[c]                  = cfg.ch[c].mode;
    end
    assign cmp_bias = cfg.cmp;

    // R3: a foreign address never triggers a load
    p_addr_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (cand.addr != node_addr) |-> !hit);

    // R2: a damaged sync word never triggers a load
    p_sync_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (cand.sync != SYNC_WORD) |-> !hit);

endmodule

// File: tb/cfgrx_top_tb_top.sv
`timescale 1ns/1ps
module cfgrx_top_tb_top;

    localparam logic [7:0] MY_ADDR = 8'hA5;
    localparam logic [12:0] SW = 13'b1111100110101;

    typedef struct packed {
        logic [12:0] hdr;
        logic [7:0]  adr;
        logic [34:0] pay;
        logic [3:0]  pre;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{13'h1F35, 8'hA5, 35'h1_2345_6789, 4'd0},
        '{13'h1F35, 8'hA4, 35'h7_FFFF_FFFF, 4'd0},
        '{13'h1F34, 8'hA5, 35'h7_FFFF_FFFF, 4'd0},
        '{13'h1F35, 8'hA5, 35'h7_FFFF_FFFF, 4'd0},
        '{13'h1F35, 8'h5A, 35'h0_0000_0000, 4'd2},
        '{13'h1F35, 8'hA5, 35'h5_5555_5555, 4'd3},
        '{13'h1F35, 8'hA5, 35'h0_0000_0000, 4'd1},
        '{13'h0F35, 8'hA5, 35'h2_AAAA_AAAA, 4'd0},
        '{13'h1F35, 8'hA5, 35'h6_0F0F_1E3C, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_data = 1'b0;
    logic [15:0] bias_code;
    logic [11:0] gain_code;
    logic [3:0]  mode_bits;
    logic [2:0]  cmp_bias;

    int n_chk  = 0;
    int n_fail = 0;
    logic [34:0] exp_pay = '0;

    always #2 clk = ~clk;

    cfgrx_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .ser_data  (ser_data),
        .node_addr (MY_ADDR),
        .bias_code (bias_code),
        .gain_code (gain_code),
        .mode_bits (mode_bits),
        .cmp_bias  (cmp_bias)
    );

    // port image expected for a payload, per the R4/R5 field placement
    function automatic logic [34:0] port_image(logic [34:0] p);
        logic [15:0] b;
        logic [11:0] g;
        logic [3:0]  m;
        for (int c = 0; c < 4; c++) begin
            b[4*c +: 4] = p[34-8*c -: 4];
            g[3*c +: 3] = p[30-8*c -: 3];
            m[c]        = p[27-8*c];
        end
        return {b, g, m, p[2:0]};
    endfunction

    // called at a falling edge; leaves the bench at a falling edge
    task automatic send_bits(input logic [127:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [34:0] p);
        logic [34:0] got;
        logic [34:0] exp;
        got = {bias_code, gain_code, mode_bits, cmp_bias};
        exp = port_image(p);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8 reset state", '0);

        // R1: 55 bits give no change, the 56th applies the payload
        send_bits({72'd0, SW, MY_ADDR, 35'h3_1357_9BDF} >> 1, 55);
        check("R1 before last bit", '0);
        send_bits(128'd1, 1);
        exp_pay = 35'h3_1357_9BDF;
        check("R1 after last bit", exp_pay);

        // table of vectors: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            vec_t  v;
            logic  acc;
            string tag;
            v = VECS[i];
            for (int k = 0; k < int'(v.pre); k++) send_bits({127'd0, ~k[0]}, 1);
            send_bits({72'd0, v.hdr, v.adr, v.pay}, 56);
            acc = (v.hdr == SW) && (v.adr == MY_ADDR);
            if (acc) exp_pay = v.pay;
            if (v.hdr != SW)            tag = "R2 R7 bad sync";
            else if (v.adr != MY_ADDR)  tag = "R3 R7 foreign address";
            else if (v.pre != 4'd0)     tag = "R6 R4 R5 misaligned start";
            else                        tag = "R4 R5 accepted payload";
            check(tag, exp_pay);
        end

        // R9: tail of an accepted packet starts the next one
        send_bits({51'd0, SW, MY_ADDR, SW, MY_ADDR, 14'h2C3D, 21'h0B7E1}, 77);
        exp_pay = {14'h2C3D, 21'h0B7E1};
        check("R9 chained packet", exp_pay);

        // R8: reset in mid run clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_pay = '0;
        check("R8 mid-run reset", exp_pay);

        // R8: cleared window must not complete a half-sent packet
        send_bits({100'd0, 6'd0, SW, MY_ADDR}, 21);
        send_bits({93'd0, 35'h4_4444_4444}, 35);
        exp_pay = 35'h4_4444_4444;
        check("R8 R4 after reset", exp_pay);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule